// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital sequencer of a successive-approximation analogue-to-digital converter. It presents a trial code to an external DAC, reads one comparator bit back each clock period, and settles one result bit per period. The most significant bit is settled first and the least significant bit last. The analogue parts stay outside the block. The only analogue-facing signals are the registered DAC code and the comparator input.

A one-cycle start pulse in the idle state loads a trial code that has only its top bit set. In each following period the comparator verdict decides the bit under test, and the next lower bit is set to 1 to form the next trial. Each decided bit leaves at once on a serial output with a valid strobe. After the last bit, the complete code appears on a parallel bus with a one-cycle done pulse. A conversion of N bits always takes N periods, whatever the input level.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the cycle after it, the DAC code, the parallel result, busy, done and the serial strobe are all 0.
- R2: A start pulse sampled while idle makes busy 1 from the next cycle, and the DAC code then holds only its top bit set (4'b1000 for N=4).
- R3: When the comparator reads 1 (input above the DAC level), the bit under test stays at 1. When it reads 0, that bit is cleared. In both cases the next lower bit is set to 1, so an input of 5.2 LSB gives the trial codes 1000, 0100, 0110, 0101.
- R4: Busy stays high for exactly N consecutive cycles per conversion, independent of the comparator values.
- R5: Each decision produces a serial-valid strobe in the cycle after the decision, with the serial bit equal to the comparator value of that decision. There are N strobes per conversion and the most significant bit comes first.
- R6: Done is a single-cycle pulse in the cycle after the last decision. The parallel result changes only in that cycle and then holds until the next conversion ends.
- R7: A start pulse sampled while busy is ignored: the running sequence, its length and its result are unchanged. This includes a start pulse in the final decision period.
- R8: When done is high, the parallel result equals the DAC code, which is the trial register after the least significant decision (0101 for 5.2 LSB, 0111 for exactly 8.0 LSB).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| cmp_i | input | 1 | Comparator verdict: 1 when the input is above the DAC level |
| dac_code_o | output | N | Registered trial code driven to the DAC |
| busy_o | output | 1 | High during the N decision periods |
| ser_bit_o | output | 1 | Most recently decided bit |
| ser_vld_o | output | 1 | Strobe qualifying ser_bit_o |
| result_o | output | N | Parallel conversion result |
| done_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
The last serial strobe and the done pulse fall in the same cycle, because both come from the least significant decision. The bench checks that the final serial bit agrees with bit 0 of the new parallel result. A start pulse can also collide with the final decision period, where the sequencer is about to return to idle. The bench drives start in exactly that period and expects busy to stay low afterwards, with no extra trial codes or strobes appearing in the scoreboard.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    SAR_IDLE = 1'b0,
    SAR_RUN  = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output logic          load_o,
  output logic          decide_o,
  output logic          last_o
);
  localparam logic [IW-1:0] TOP_IDX = IW'(N - 1);

  sar_state_e      state_q;
  logic [IW-1:0]   idx_q;

  assign load_o   = (state_q == SAR_IDLE) && start_i;
  assign decide_o = (state_q == SAR_RUN);
  assign last_o   = decide_o && (idx_q == '0);
  assign busy_o   = decide_o;
  assign idx_o    = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SAR_IDLE;
      idx_q   <= '0;
    end else if (load_o) begin
      state_q <= SAR_RUN;
      idx_q   <= TOP_IDX;
    end else if (last_o) begin
      state_q <= SAR_IDLE;
    end else if (decide_o) begin
      idx_q   <= idx_q - 1'b1;
    end
  end
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          decide_i,
  input  logic [IW-1:0] idx_i,
  input  logic          cmp_i,
  output logic [N-1:0]  trial_o,
  output logic [N-1:0]  next_o
);
  // first trial of a conversion: only the top bit set
  function automatic logic [N-1:0] first_trial();
    logic [N-1:0] c;
    c = '0;
    c[N-1] = 1'b1;
    return c;
  endfunction

  // settle bit pos from the comparator, then arm the next lower bit
  function automatic logic [N-1:0] settle(input logic [N-1:0] code,
                                          input int unsigned  pos,
                                          input logic         keep);
    logic [N-1:0] c;
    c = code;
    c[pos] = keep;
    if (pos > 0) c[pos-1] = 1'b1;
    return c;
  endfunction

  logic [N-1:0] trial_q;

  assign next_o  = settle(trial_q, int'(idx_i), cmp_i);
  assign trial_o = trial_q;

  always_ff @(posedge clk) begin
    if (rst)           trial_q <= '0;
    else if (load_i)   trial_q <= first_trial();
    else if (decide_i) trial_q <= next_o;
  end
endmodule

// File: rtl/sar_serial.sv
module sar_serial (
  input  logic clk,
  input  logic rst,
  input  logic decide_i,
  input  logic cmp_i,
  output logic ser_bit_o,
  output logic ser_vld_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ser_bit_o <= 1'b0;
      ser_vld_o <= 1'b0;
    end else begin
      ser_vld_o <= decide_i;
      ser_bit_o <= decide_i ? cmp_i : 1'b0;
    end
  end
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         last_i,
  input  logic [N-1:0] final_i,
  output logic [N-1:0] result_o,
  output logic         done_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= last_i;
      if (last_i) result_o <= final_i;
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         cmp_i,
  output logic [N-1:0] dac_code_o,
  output logic         busy_o,
  output logic         ser_bit_o,
  output logic         ser_vld_o,
  output logic [N-1:0] result_o,
  output logic         done_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  // named internal events, visible to the bound checker
  logic          ev_load;
  logic          ev_decide;
  logic          ev_last;
  logic [IW-1:0] bit_idx;
  logic [N-1:0]  trial;
  logic [N-1:0]  trial_next;

  sar_seq #(.N(N)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .idx_o    (bit_idx),
    .load_o   (ev_load),
    .decide_o (ev_decide),
    .last_o   (ev_last)
  );

  sar_trial #(.N(N)) u_trial (
    .clk      (clk),
    .rst      (rst),
    .load_i   (ev_load),
    .decide_i (ev_decide),
    .idx_i    (bit_idx),
    .cmp_i    (cmp_i),
    .trial_o  (trial),
    .next_o   (trial_next)
  );

  sar_serial u_ser (
    .clk       (clk),
    .rst       (rst),
    .decide_i  (ev_decide),
    .cmp_i     (cmp_i),
    .ser_bit_o (ser_bit_o),
    .ser_vld_o (ser_vld_o)
  );

  sar_result #(.N(N)) u_res (
    .clk      (clk),
    .rst      (rst),
    .last_i   (ev_last),
    .final_i  (trial_next),
    .result_o (result_o),
    .done_o   (done_o)
  );

  assign dac_code_o = trial;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          cmp_i,
  input logic [N-1:0]  dac_code_o,
  input logic          busy_o,
  input logic          ser_bit_o,
  input logic          ser_vld_o,
  input logic [N-1:0]  result_o,
  input logic          done_o,
  input logic          ev_last,
  input logic [IW-1:0] bit_idx
);
  localparam logic [N-1:0] TOP_ONLY = {1'b1, {(N-1){1'b0}}};

  int unsigned run_q;
  always_ff @(posedge clk) begin
    if (rst)         run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (dac_code_o == '0 && result_o == '0 && !busy_o && !done_o && !ser_vld_o));

  // R2
  first_trial_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> dac_code_o == TOP_ONLY);

  // R3
  bit_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> dac_code_o[$past(bit_idx)] == $past(cmp_i));

  // R4
  fixed_len_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> run_q == N);

  // R5
  ser_follow_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (ser_vld_o && ser_bit_o == $past(cmp_i)));

  // R5
  ser_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> !ser_vld_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_o) |-> done_o);

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !ev_last) |=> (busy_o && dac_code_o != TOP_ONLY));

  // R8
  result_match_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (result_o == dac_code_o && result_o[0] == ser_bit_o));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .cmp_i      (cmp_i),
  .dac_code_o (dac_code_o),
  .busy_o     (busy_o),
  .ser_bit_o  (ser_bit_o),
  .ser_vld_o  (ser_vld_o),
  .result_o   (result_o),
  .done_o     (done_o),
  .ev_last    (ev_last),
  .bit_idx    (bit_idx)
);

// File: tb/sar_conv_ctrl_tb.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb;
  localparam int N = 4;
  localparam int TOP = 1 << (N - 1);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         cmp_i;
  logic [N-1:0] dac_code_o;
  logic         busy_o;
  logic         ser_bit_o;
  logic         ser_vld_o;
  logic [N-1:0] result_o;
  logic         done_o;

  int vin_x10 = 0;   // analogue input in tenths of an LSB
  int n_chk = 0;
  int n_fail = 0;
  bit sb_on = 1'b0;
  bit finished = 1'b0;

  int q_dac[$];
  int q_ser[$];
  int q_res[$];

  always #2 clk = ~clk;   // 250 MHz

  // behavioural comparator: 1 when input above DAC level
  assign cmp_i = (vin_x10 > int'(dac_code_o) * 10);

  sar_conv_ctrl #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .cmp_i(cmp_i),
    .dac_code_o(dac_code_o), .busy_o(busy_o), .ser_bit_o(ser_bit_o),
    .ser_vld_o(ser_vld_o), .result_o(result_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (sb_on && !rst) begin
      if (busy_o) begin
        if (q_dac.size() == 0) chk(0, "R3", "unexpected trial code", int'(dac_code_o), -1);
        else begin
          int e; e = q_dac.pop_front();
          chk(int'(dac_code_o) == e, "R3", "trial code", int'(dac_code_o), e);
        end
      end
      if (ser_vld_o) begin
        if (q_ser.size() == 0) chk(0, "R5", "unexpected serial strobe", int'(ser_bit_o), -1);
        else begin
          int e; e = q_ser.pop_front();
          chk(int'(ser_bit_o) == e, "R5", "serial bit", int'(ser_bit_o), e);
        end
      end
      if (done_o) begin
        if (q_res.size() == 0) chk(0, "R8", "unexpected result", int'(result_o), -1);
        else begin
          int e; e = q_res.pop_front();
          chk(int'(result_o) == e, "R8", "parallel result", int'(result_o), e);
          chk(int'(dac_code_o) == e, "R8", "dac code at done", int'(dac_code_o), e);
        end
      end
    end
  end

  // driver: computes expected sequence, then runs one conversion
  task automatic run_conv(input int vin10, input int mid_start, input bit late_start);
    int code;
    code = TOP;
    vin_x10 = vin10;
    for (int i = N - 1; i >= 0; i--) begin
      bit b;
      q_dac.push_back(code);
      b = (vin10 > code * 10);
      q_ser.push_back(int'(b));
      if (!b) code = code & ~(1 << i);
      if (i > 0) code = code | (1 << (i - 1));
    end
    q_res.push_back(code);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int c = 0; c < N; c++) begin
      if (c > 0) @(negedge clk);
      chk(busy_o == 1'b1, "R4", "busy during period", int'(busy_o), 1);
      // R7: start pulses during the conversion are to be ignored
      start_i = (c == mid_start) || (late_start && c == N - 1);
    end
    @(negedge clk) start_i = 1'b0;
    chk(done_o == 1'b1, "R6", "done after N periods", int'(done_o), 1);
    chk(busy_o == 1'b0, "R4", "busy drops after N periods", int'(busy_o), 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R6", "done is one cycle", int'(done_o), 0);
    chk(busy_o == 1'b0, "R7", "no restart from start while busy", int'(busy_o), 0);
    repeat (2) begin
      @(negedge clk);
      chk(int'(result_o) == code, "R6", "result holds", int'(result_o), code);
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dac_code_o == '0, "R1", "dac code in reset", int'(dac_code_o), 0);
    chk(result_o == '0, "R1", "result in reset", int'(result_o), 0);
    chk(busy_o == 1'b0, "R1", "busy in reset", int'(busy_o), 0);
    chk(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
    chk(ser_vld_o == 1'b0, "R1", "serial strobe in reset", int'(ser_vld_o), 0);
    rst = 1'b0;
    sb_on = 1'b1;

    // R2: first trial only top bit set
    vin_x10 = 52;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(int'(dac_code_o) == TOP, "R2", "first trial code", int'(dac_code_o), TOP);
    chk(busy_o == 1'b1, "R2", "busy after start", int'(busy_o), 1);
    sb_on = 1'b0;
    // R1: reset mid conversion
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(dac_code_o == '0, "R1", "dac code after mid reset", int'(dac_code_o), 0);
    chk(busy_o == 1'b0, "R1", "idle after mid reset", int'(busy_o), 0);
    @(negedge clk);
    sb_on = 1'b1;

    // R3 / R8: 5.2 LSB gives 1000,0100,0110,0101
    run_conv(52, -1, 1'b0);
    run_conv(0, -1, 1'b0);      // all bits cleared
    run_conv(159, -1, 1'b0);    // full scale
    run_conv(80, -1, 1'b0);     // equal to DAC level: 0111
    run_conv(75, 1, 1'b0);      // R7: start in period 1 ignored
    run_conv(113, -1, 1'b1);    // R7: start in final period ignored
    run_conv(31, 0, 1'b1);

    repeat (2) @(negedge clk);
    chk(q_dac.size() == 0, "R4", "pending trial codes", q_dac.size(), 0);
    chk(q_ser.size() == 0, "R5", "pending serial bits", q_ser.size(), 0);
    chk(q_res.size() == 0, "R8", "pending results", q_res.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung act=%0d exp=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule